// File: doc/BRIEF.md
# Pixel Clock Divider and Shift Clock Gate

This block sits beside the output stage of a video pipeline and turns one fast pixel clock into the slower clocks that the rest of that stage needs. It makes a load strobe at the pixel rate divided by the pixel multiplex factor. The strobe tells upstream logic when to present the next group of pixels.

It also makes a free-running auxiliary clock whose divide ratio is picked by a 2-bit setting. The third output is a copy of an external video shift clock that is stopped for the whole blanking interval.

Both dividers pick up a new setting only when their count wraps, so a setting change never produces a short pulse. The shift-clock gate samples the active-low blank input in the shift-clock domain, while that clock is low, so every pulse it passes is a whole pulse.

Top module: `pixclk_aux_gen`

## Requirements
- R1: The 2-bit `mux_mode` input selects the load strobe divide factor M. Code 00 gives M = 1, code 01 gives M = 2, and codes 10 and 11 both give M = 4.
- R2: While M = 1 and reset is not asserted, `ld_strobe` equals the pixel clock `clk`.
- R3: While M is 2 or 4, `ld_strobe` is high for the first M/2 pixel clock cycles of each M-cycle group and low for the remaining M/2 cycles. It rises on the pixel clock edge that starts a group. The first rising edge of `clk` after reset is released starts a group.
- R4: `prg_clk` divides `clk` by N with a 50% duty cycle. `prg_sel` 00 gives N = 4, 01 gives N = 8, 10 gives N = 16 and 11 gives N = 32. The output rises on the edge that starts each N-cycle period, and the first edge after reset starts a period.
- R5: A change of `mux_mode` or `prg_sel` takes effect only on the edge that ends the current group or period. No high or low phase is ever cut short.
- R6: Reset is synchronous and active high. From the first rising edge of `clk` on which `rst` is high, both counters are cleared and `ld_strobe` and `prg_clk` stay low until reset is released.
- R7: `sck_out` equals `sck_in` while `blank_n` is high. It stays low for the whole time `blank_n` is low. The enable is taken from `blank_n` while `sck_in` is low and held while `sck_in` is high.
- R8: A change of `blank_n` while `sck_in` is high does not alter `sck_out` until `sck_in` next goes low. A pulse that has started runs to its end, and no partial pulse is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_mode | input | 2 | Pixel multiplex factor select (00 /1, 01 /2, 1x /4) |
| prg_sel | input | 2 | Auxiliary clock divide select (00 /4, 01 /8, 10 /16, 11 /32) |
| sck_in | input | 1 | External video shift clock |
| blank_n | input | 1 | Blanking, active low |
| ld_strobe | output | 1 | Pixel group load strobe |
| prg_clk | output | 1 | Programmable divided clock |
| sck_out | output | 1 | Shift clock, stopped during blanking |

## Verification
The bench builds the block with its default parameters. These give a 2-bit multiplex select whose largest factor is 4, and a 2-bit divide select starting at 4, so the auxiliary counter is five bits wide. With those values every multiplex code, including the aliased code 11, and all four divide ratios up to 32 are reached within a few hundred pixel cycles. The bench changes settings part way through a group and asserts reset in the middle of a run. The shift clock runs unrelated to the pixel clock, and blank toggles at phases that fall both inside high pulses and inside low phases of the shift clock.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

  // Multiplex factor codes as seen on the mode input
  typedef enum logic [1:0] {
    MUX_X1  = 2'b00,
    MUX_X2  = 2'b01,
    MUX_X4  = 2'b10,
    MUX_X4A = 2'b11
  } mux_mode_e;

  // Default log2 of the largest multiplex factor
  localparam int MUX_MAX_LOG2_DEF = 2;
  // Default log2 of the smallest programmable divide ratio
  localparam int PRG_MIN_LOG2_DEF = 2;
  // Default width of the programmable divide select
  localparam int PRG_SEL_W_DEF    = 2;

endpackage

// File: rtl/ratio_divider.sv
// Power-of-two clock divider with a square-wave output. A new ratio is
// picked up only on the edge that wraps the count.
module ratio_divider #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W:0]   ratio_req,
  output logic             hi_o,
  output logic             run_o,
  output logic [CNT_W:0]   ratio_o
);

  localparam int RW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    ratio_q;
  logic [RW-1:0]    cnt_ext;
  logic [RW-1:0]    cnt_nxt;
  logic             hi_q;
  logic             run_q;
  logic             wrap;

  assign cnt_ext = {1'b0, cnt_q};
  assign cnt_nxt = cnt_ext + RW'(1);
  assign wrap    = (cnt_ext >= (ratio_q - RW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      ratio_q <= ratio_req;
      hi_q    <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (wrap) begin
        cnt_q   <= '0;
        ratio_q <= ratio_req;
        hi_q    <= (ratio_req > RW'(1));
      end else begin
        cnt_q <= cnt_nxt[CNT_W-1:0];
        hi_q  <= (cnt_nxt < (ratio_q >> 1));
      end
    end
  end

  assign hi_o    = hi_q;
  assign run_o   = run_q;
  assign ratio_o = ratio_q;

  // R3: the output only rises at the start of a group
  assert_rise_at_group_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> (cnt_q == '0));

  // R3: the output falls exactly half way through a group
  assert_fall_at_half_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_q) |-> (cnt_ext == (ratio_q >> 1)));

  // R5: the active ratio moves only on a wrap
  assert_ratio_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_q) |-> (cnt_q == '0));

  // R5: while running the count never leaves the active ratio
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_ext < ratio_q));

  // R6: a reset edge leaves the output low and the divider idle
  assert_reset_low_R6: assert property (@(posedge clk)
    rst |=> (!hi_q && !run_q));

endmodule

// File: rtl/shift_clk_gate.sv
// Glitch-free gate for the external shift clock. The enable follows
// blank_n only while the shift clock is low.
module shift_clk_gate (
  input  logic sck_in,
  input  logic blank_n,
  output logic sck_out
);

  logic en_l;

  always_latch begin
    if (!sck_in) en_l = blank_n;
  end

  assign sck_out = sck_in & en_l;

endmodule

// File: rtl/pixclk_aux_gen.sv
module pixclk_aux_gen
  import pixclk_pkg::*;
#(
  parameter int MUX_MAX_LOG2 = MUX_MAX_LOG2_DEF,
  parameter int PRG_MIN_LOG2 = PRG_MIN_LOG2_DEF,
  parameter int PRG_SEL_W    = PRG_SEL_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mux_mode,
  input  logic [PRG_SEL_W-1:0] prg_sel,
  input  logic                 sck_in,
  input  logic                 blank_n,
  output logic                 ld_strobe,
  output logic                 prg_clk,
  output logic                 sck_out
);

  localparam int LD_CNT_W  = (MUX_MAX_LOG2 < 1) ? 1 : MUX_MAX_LOG2;
  localparam int PRG_CNT_W = PRG_MIN_LOG2 + (1 << PRG_SEL_W) - 1;
  localparam int LD_RW     = LD_CNT_W + 1;
  localparam int PRG_RW    = PRG_CNT_W + 1;

  logic [LD_RW-1:0]  ld_ratio_req;
  logic [LD_RW-1:0]  ld_ratio;
  logic              ld_hi;
  logic              ld_run;
  logic [PRG_RW-1:0] prg_ratio_req;
  logic [PRG_RW-1:0] prg_ratio;
  logic              prg_hi;
  logic              prg_run;
  int unsigned       ld_shift;

  // Multiplex code to factor; codes past the largest factor saturate
  always_comb begin
    ld_shift = (int'(mux_mode) > MUX_MAX_LOG2) ? MUX_MAX_LOG2 : int'(mux_mode);
    ld_ratio_req = LD_RW'(1) << ld_shift;
  end

  assign prg_ratio_req = PRG_RW'(1) << (PRG_MIN_LOG2 + int'(prg_sel));

  ratio_divider #(.CNT_W(LD_CNT_W)) u_ld_div (
    .clk       (clk),
    .rst       (rst),
    .ratio_req (ld_ratio_req),
    .hi_o      (ld_hi),
    .run_o     (ld_run),
    .ratio_o   (ld_ratio)
  );

  ratio_divider #(.CNT_W(PRG_CNT_W)) u_prg_div (
    .clk       (clk),
    .rst       (rst),
    .ratio_req (prg_ratio_req),
    .hi_o      (prg_hi),
    .run_o     (prg_run),
    .ratio_o   (prg_ratio)
  );

  // Factor 1 passes the pixel clock straight through once running
  assign ld_strobe = (ld_ratio == LD_RW'(1)) ? (clk & ld_run) : ld_hi;
  assign prg_clk   = prg_hi;

  shift_clk_gate u_sck_gate (
    .sck_in  (sck_in),
    .blank_n (blank_n),
    .sck_out (sck_out)
  );

  // R4: the auxiliary ratio is always one of the selectable powers of two
  assert_prg_ratio_R4: assert property (@(posedge clk) disable iff (rst)
    prg_run |-> ($countones(prg_ratio) == 1 && prg_ratio >= PRG_RW'(1 << PRG_MIN_LOG2)));

  // R1: the load ratio is a single power of two within the largest factor
  assert_ld_ratio_R1: assert property (@(posedge clk) disable iff (rst)
    ld_run |-> ($countones(ld_ratio) == 1 && ld_ratio <= LD_RW'(1 << LD_CNT_W)));

endmodule

// File: tb/pixclk_aux_gen_bench.sv
`timescale 1ns/1ps
module pixclk_aux_gen_bench;

  localparam real CLK_PERIOD = 10.0;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mux_mode = 2'b00;
  logic [1:0] prg_sel = 2'b00;
  logic       sck_in = 1'b0;
  logic       blank_n = 1'b1;
  logic       ld_strobe, prg_clk, sck_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  pixclk_aux_gen u_pixclk_aux_gen (
    .clk(clk), .rst(rst), .mux_mode(mux_mode), .prg_sel(prg_sel),
    .sck_in(sck_in), .blank_n(blank_n),
    .ld_strobe(ld_strobe), .prg_clk(prg_clk), .sck_out(sck_out)
  );

  initial forever #(CLK_PERIOD/2.0) clk = ~clk;
  initial begin #1; forever #13 sck_in = ~sck_in; end

  // Behavioural reference
  function automatic int mux_factor(logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  int l_act, l_pos, p_act, p_pos;
  bit l_hi, l_run, p_hi, p_sw;
  bit sck_en = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      l_act = mux_factor(mux_mode); l_pos = l_act - 1; l_hi = 0; l_run = 0;
      p_act = 4 << prg_sel;         p_pos = p_act - 1; p_hi = 0; p_sw = 0;
    end else begin
      l_run = 1;
      l_pos++;
      if (l_pos >= l_act) begin l_pos = 0; l_act = mux_factor(mux_mode); end
      l_hi = (l_pos < l_act / 2);
      p_pos++;
      if (p_pos >= p_act) begin
        p_pos = 0;
        p_sw  = (p_act != (4 << prg_sel));
        p_act = 4 << prg_sel;
      end
      p_hi = (p_pos < p_act / 2);
    end
  end

  always @(posedge sck_in) sck_en = blank_n;

  task automatic check(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %0b expected %0b", tag, what, $time, act, exp);
    end
  endtask

  task automatic compare(bit clk_high);
    logic e_ld;
    string ld_tag, p_tag, s_tag;
    e_ld   = (l_act == 1) ? (clk_high & l_run) : l_hi;
    ld_tag = rst ? "R6" : (l_act == 1) ? "R2" : (l_act == 2) ? "R3" : "R1";
    p_tag  = rst ? "R6" : p_sw ? "R5" : "R4";
    s_tag  = (sck_in && sck_en != blank_n) ? "R8" : "R7";
    check(ld_tag, "ld_strobe", ld_strobe, e_ld);
    check(p_tag,  "prg_clk",   prg_clk,   p_hi);
    check(s_tag,  "sck_out",   sck_out,   sck_in & sck_en);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4.0)     if (!done) compare(1'b1);
    #(CLK_PERIOD/2.0)     if (!done) compare(1'b0);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #0.7;
  endtask

  // Blanking toggles on a 9-cycle rhythm against a 2.6-cycle shift clock (R7, R8)
  initial begin
    forever begin
      step(9);
      blank_n = ~blank_n;
    end
  end

  initial begin
    // R6: outputs held low while in reset
    step(4);
    rst = 1'b0;
    step(10);                     // R2: factor 1, R4: divide by 4
    mux_mode = 2'b01; prg_sel = 2'b01;
    step(13);                     // R5: changes land on wraps
    mux_mode = 2'b10;
    step(3);
    prg_sel = 2'b10;
    step(45);                     // R1: factor 4, divide by 16
    mux_mode = 2'b11; prg_sel = 2'b11;
    step(70);                     // R1: alias code, divide by 32
    prg_sel = 2'b00; mux_mode = 2'b00;
    step(37);                     // R5: shrink ratios mid period
    mux_mode = 2'b01;
    step(5);
    rst = 1'b1; mux_mode = 2'b10; // R6: reset mid run
    step(4);
    rst = 1'b0;
    step(40);                     // R3: first edge after reset starts a group
    prg_sel = 2'b01; mux_mode = 2'b01;
    step(30);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule